// File: doc/BRIEF.md
# Full-Step Quadrature Phase Generator

This block drives the four coil phases of a bipolar stepper motor with full steps. A single free-running up counter counts from zero to a programmed period and then wraps. The first phase pair (A and its complement C) flips when the counter reads 1. The second pair (B and its complement D) flips when the counter reads half the period plus one. Each phase therefore completes one cycle every two counter periods, and the B/D pair trails the A/C pair by a quarter of a cycle.

Rotation direction comes only from the levels loaded into the phase flops when the generator starts. The B/D pair starts high for forward rotation and low for reverse. Speed is set through a period value. A written period sits in a shadow register and takes effect at the next counter wrap, so no compare point in the current turn is lost or repeated. The generator emits a one-clock reload pulse at every wrap, which an external speed profile can use to supply the next period. Typical profiles change the period by about 2% or less per step.

Top module: `stepgen_top`

## Requirements
- R1: C is always the inverse of A, and D is always the inverse of B, in every cycle after reset.
- R2: While running with period P, the counter covers 0..P, so one turn lasts P+1 clocks. `reload_pulse` is high for exactly one clock after each wrap, at clock edges (P+1)·n counted from the start edge, and is low otherwise.
- R3: A and C flip on the edge where the counter reads 1: edge 2 after the start edge, then every P+1 edges.
- R4: B and D flip on the edge where the counter reads floor(P/2)+1.
- R5: Starting with `dir_rev`=0 loads A=1, B=1, C=0, D=0 and clears the counter.
- R6: Starting with `dir_rev`=1 loads A=1, B=0, C=0, D=1 and clears the counter.
- R7: After reset the generator is stopped, the outputs are A=1, B=1, C=0, D=0, `reload_pulse` is 0, and the period is 4000.
- R8: A period written while running takes effect at the next wrap. A write strobed in the same clock as a wrap governs the turn that begins at that wrap.
- R9: A written period below 4 is replaced by 4.
- R10: With `run_en` low, the counter and all four phases hold and no reload pulse is issued. The next rising `run_en` applies the direction preset and restarts the counter from zero.
- R11: Changes on `dir_rev` while running have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | High to run; a rising level starts with the preset |
| dir_rev | input | 1 | 0 forward, 1 reverse; sampled only at start |
| period_wr | input | 1 | Strobe that writes `period_in` into the shadow register |
| period_in | input | CNT_W | New counter period (top count) |
| ph_a | output | 1 | Phase A level |
| ph_b | output | 1 | Phase B level |
| ph_c | output | 1 | Phase C level (inverse of A) |
| ph_d | output | 1 | Phase D level (inverse of B) |
| reload_pulse | output | 1 | One-clock pulse after each counter wrap |

## Verification
A period write and a counter wrap can fall in the same clock. The bench forces this by raising the write strobe in exactly the cycle in which the counter holds its top value. It then judges the outcome from the spacing of the next reload pulses and from the edges on which A and B flip afterwards. A second collision occurs when `dir_rev` toggles mid-run while compare points fire. The bench checks that every phase edge still matches the arithmetic forward pattern.

// File: rtl/stepgen_pkg.sv
package stepgen_pkg;
  // Four coil levels held together so they update as one register.
  typedef struct packed {
    logic a;
    logic b;
    logic c;
    logic d;
  } phase_t;

  localparam phase_t PH_RESET = '{a: 1'b1, b: 1'b1, c: 1'b0, d: 1'b0};
endpackage

// File: rtl/stepgen_period.sv
module stepgen_period #(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned DEF_PERIOD = 4000,
  parameter int unsigned MIN_PERIOD = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_val,
  input  logic             load,
  output logic [CNT_W-1:0] act_per,
  output logic [CNT_W-1:0] half_pt
);
  localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_PERIOD);
  localparam logic [CNT_W-1:0] DEF_V = CNT_W'(DEF_PERIOD);

  logic [CNT_W-1:0] shadow_q, shadow_d;
  logic [CNT_W-1:0] act_q, act_d;
  logic [CNT_W-1:0] clamped;

  always_comb begin
    clamped  = (wr_val < MIN_V) ? MIN_V : wr_val;
    shadow_d = wr_en ? clamped : shadow_q;
    // A write in the load cycle bypasses the shadow flop.
    act_d    = load ? shadow_d : act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= DEF_V;
      act_q    <= DEF_V;
    end else begin
      shadow_q <= shadow_d;
      act_q    <= act_d;
    end
  end

  assign act_per = act_q;
  assign half_pt = (act_q >> 1) + CNT_W'(1);
endmodule

// File: rtl/stepgen_counter.sv
module stepgen_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic [CNT_W-1:0] top,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    wrap  = run && (cnt_q == top);
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (wrap) cnt_d = '0;
    else if (run)  cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/stepgen_phase.sv
module stepgen_phase
  import stepgen_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   preset,
  input  logic   rev,
  input  logic   hit_ac,
  input  logic   hit_bd,
  output phase_t ph
);
  phase_t ph_q, ph_d;

  always_comb begin
    ph_d = ph_q;
    if (preset) begin
      ph_d.a = 1'b1;
      ph_d.c = 1'b0;
      ph_d.b = ~rev;
      ph_d.d = rev;
    end else begin
      if (hit_ac) begin
        ph_d.a = ~ph_q.a;
        ph_d.c = ~ph_q.c;
      end
      if (hit_bd) begin
        ph_d.b = ~ph_q.b;
        ph_d.d = ~ph_q.d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_RESET;
    else        ph_q <= ph_d;
  end

  assign ph = ph_q;
endmodule

// File: rtl/stepgen_top.sv
module stepgen_top
  import stepgen_pkg::*;
#(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned DEF_PERIOD = 4000,
  parameter int unsigned MIN_PERIOD = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             dir_rev,
  input  logic             period_wr,
  input  logic [CNT_W-1:0] period_in,
  output logic             ph_a,
  output logic             ph_b,
  output logic             ph_c,
  output logic             ph_d,
  output logic             reload_pulse
);
  logic [1:0]       rst_sync_q;
  logic             rst_n_s;
  logic             running_q;
  logic             start, live, wrap;
  logic [CNT_W-1:0] cnt_q, act_per, half_pt;
  logic             reload_q, reload_d;
  phase_t           ph;

  // Reset asserts at once and releases on the second clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  always_comb begin
    start    = run_en && !running_q;
    live     = run_en && running_q;
    reload_d = wrap;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      running_q <= 1'b0;
      reload_q  <= 1'b0;
    end else begin
      running_q <= run_en;
      reload_q  <= reload_d;
    end
  end

  stepgen_period #(
    .CNT_W(CNT_W), .DEF_PERIOD(DEF_PERIOD), .MIN_PERIOD(MIN_PERIOD)
  ) u_period (
    .clk(clk), .rst_n(rst_n_s), .wr_en(period_wr), .wr_val(period_in),
    .load(start || wrap), .act_per(act_per), .half_pt(half_pt)
  );

  stepgen_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n_s), .clr(start), .run(live), .top(act_per),
    .cnt(cnt_q), .wrap(wrap)
  );

  stepgen_phase u_phase (
    .clk(clk), .rst_n(rst_n_s), .preset(start), .rev(dir_rev),
    .hit_ac(live && (cnt_q == CNT_W'(1))),
    .hit_bd(live && (cnt_q == half_pt)),
    .ph(ph)
  );

  assign ph_a         = ph.a;
  assign ph_b         = ph.b;
  assign ph_c         = ph.c;
  assign ph_d         = ph.d;
  assign reload_pulse = reload_q;
endmodule

// File: rtl/stepgen_chk.sv
module stepgen_chk #(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned MIN_PERIOD = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_en,
  input logic             dir_rev,
  input logic             ph_a,
  input logic             ph_b,
  input logic             ph_c,
  input logic             ph_d,
  input logic             reload_pulse,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] per
);
  // R1
  ac_inverse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ph_a != ph_c);
  // R1
  bd_inverse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ph_b != ph_d);
  // R2
  reload_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload_pulse |=> !reload_pulse);
  // R2
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= per);
  // R9
  per_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    per >= CNT_W'(MIN_PERIOD));
  // R10
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> ($stable(ph_a) && $stable(ph_b) && !reload_pulse));
  // R5
  start_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_en) |=> (ph_a && (ph_b == !$past(dir_rev)) && cnt == '0));
endmodule

bind stepgen_top stepgen_chk #(.CNT_W(CNT_W), .MIN_PERIOD(MIN_PERIOD)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .dir_rev(dir_rev),
  .ph_a(ph_a), .ph_b(ph_b), .ph_c(ph_c), .ph_d(ph_d),
  .reload_pulse(reload_pulse), .cnt(cnt_q), .per(act_per)
);

// File: tb/stepgen_tb_top.sv
`timescale 1ns/1ps
module stepgen_top_tb_top;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_en = 1'b0, dir_rev = 1'b0, period_wr = 1'b0;
  logic [W-1:0] period_in = '0;
  logic ph_a, ph_b, ph_c, ph_d, reload_pulse;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  stepgen_top #(.CNT_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .dir_rev(dir_rev),
    .period_wr(period_wr), .period_in(period_in),
    .ph_a(ph_a), .ph_b(ph_b), .ph_c(ph_c), .ph_d(ph_d),
    .reload_pulse(reload_pulse)
  );

  task automatic chk(input string req, input logic act, input logic exp, input int k);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s k=%0d actual=%b expected=%b", req, k, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int nflip(input int k, input int pt, input int len);
    return (k > pt) ? ((k - 1 - pt) / len + 1) : 0;
  endfunction

  task automatic chk_all(input string req, input logic ea, input logic eb,
                         input logic er, input int k);
    chk({req, "/R3 A"}, ph_a, ea, k);
    chk({req, "/R1 C"}, ph_c, ~ea, k);
    chk({req, "/R4 B"}, ph_b, eb, k);
    chk({req, "/R1 D"}, ph_d, ~eb, k);
    chk({req, "/R2 reload"}, reload_pulse, er, k);
  endtask

  task automatic wr_per(input int v);
    period_wr = 1'b1;
    period_in = W'(v);
    step();
    period_wr = 1'b0;
  endtask

  // Start at the next edge, then compare every cycle against the formulas.
  task automatic run_model(input int p, input logic rev, input int ncyc, input bit flip);
    int len, h;
    len = p + 1;
    h = p / 2 + 1;
    dir_rev = rev;
    run_en = 1'b1;
    step();
    for (int k = 0; k <= ncyc; k++) begin
      chk(rev ? "R6" : "R5", ph_b, ~rev ^ nflip(k, h, len)[0], k);
      chk_all(rev ? "R6" : "R5", 1'b1 ^ nflip(k, 1, len)[0],
              ~rev ^ nflip(k, h, len)[0], (k > 0) && (k % len == 0), k);
      if (flip && k == 3) dir_rev = ~rev;  // R11: ignored while running
      step();
    end
    run_en = 1'b0;
    step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic ea, eb, ha, hb;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) step();
    // R7 reset state
    chk_all("R7", 1'b1, 1'b1, 1'b0, 0);

    // R7 default period 4000 without any write
    run_model(4000, 1'b0, 8003, 1'b0);

    // R9 clamp and R3/R4/R5/R6/R11 sweep
    for (int p = 0; p <= 14; p++) begin
      for (int r = 0; r < 2; r++) begin
        wr_per(p);
        run_model((p < 4) ? 4 : p, r[0], 3 * ((p < 4 ? 4 : p) + 1) + 2, 1'b1);
      end
    end

    // R8 write mid-turn: P=10 then 6 after the wrap
    wr_per(10);
    dir_rev = 1'b0; run_en = 1'b1; step();
    ea = 1'b1; eb = 1'b1;
    for (int k = 0; k <= 20; k++) begin
      if (k == 2 || k == 13 || k == 20) ea = ~ea;
      if (k == 7 || k == 16) eb = ~eb;
      chk_all("R8 mid", ea, eb, (k == 11 || k == 18), k);
      if (k == 3) begin period_wr = 1'b1; period_in = W'(6); end
      if (k == 4) period_wr = 1'b0;
      step();
    end
    run_en = 1'b0; step();

    // R8 write in the wrap cycle: P=8, strobe sampled on edge 9
    wr_per(8);
    run_en = 1'b1; step();
    ea = 1'b1; eb = 1'b1;
    for (int k = 0; k <= 22; k++) begin
      if (k == 2 || k == 11 || k == 17) ea = ~ea;
      if (k == 6 || k == 13 || k == 19) eb = ~eb;
      chk_all("R8 wrap", ea, eb, (k == 9 || k == 15 || k == 21), k);
      if (k == 8) begin period_wr = 1'b1; period_in = W'(5); end
      if (k == 9) period_wr = 1'b0;
      step();
    end
    run_en = 1'b0; step();

    // R10 stop holds, restart reverse applies preset
    wr_per(6);
    dir_rev = 1'b0; run_en = 1'b1; step();
    for (int k = 0; k < 10; k++) step();
    run_en = 1'b0;
    ha = ph_a; hb = ph_b;
    for (int k = 0; k < 5; k++) begin
      step();
      dir_rev = ~dir_rev;
      chk_all("R10 hold", ha, hb, 1'b0, k);
    end
    run_model(6, 1'b1, 30, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule